// File: doc/BRIEF.md
# Stream Table Walker

This block turns a DMA requester's stream identifier into the translation setup that applies to it. A request carries a stream ID and a substream (task) ID. The walker reads the device's table entry from memory and pulls out the stage-1 and stage-2 settings. When stage 1 is on, it also fetches the per-task context descriptor. The result goes back as one response: a bypass indication, the resolved bases and VMID, or a fault code. The walker does no address translation itself.

The table base, the table layout and the table size come from quasi-static configuration inputs, which must stay stable while a request is in flight. In the flat layout the stream ID indexes the entry array directly. In the two-level layout the stream ID bits above an 8-bit split select a one-word directory descriptor, and that descriptor points to the entry array addressed by the low 8 bits. All memory traffic goes through one read port. A read is a request with a beat count, followed by that many 64-bit data beats with any number of idle cycles between them.

Top module: `stream_walker`

## Requirements
- R1: After reset, `req_ready` is 1 and both `resp_valid` and `rd_req_valid` are 0.
- R2: In flat layout (`cfg_two_level`=0) the only table read is 8 beats at `cfg_table_base + sid*64`.
- R3: In two-level layout the walker first reads 1 beat at `cfg_table_base + (sid>>8)*8`. When that directory word has bit 0 set, it then reads 8 beats at `{word[ADDR_W-1:6],6'b0} + sid[7:0]*64`.
- R4: A stream ID with a non-zero value of `sid >> cfg_log2size` (where `cfg_log2size` < SID_W) produces fault code 1 and no memory read.
- R5: A directory word with bit 0 clear produces fault code 2, and an entry whose word 0 bit 0 is clear produces fault code 3. Neither case issues any further read. Every faulted response carries zero VMID, zero bases, zero `resp_cfg`, and bypass 0.
- R6: Entry decoding: word 0 bit 1 enables stage 1 and bit 2 enables stage 2 (`resp_cfg` = {bit2, bit1}). Word 3 bits [VMID_W-1:0] give the VMID. `resp_s2_ttb` is word 2 with bits [11:0] cleared when stage 2 is on, and 0 otherwise.
- R7: An entry with both stages off returns `resp_bypass`=1, zero bases, and no descriptor read.
- R8: With stage 1 on, the walker reads 8 beats at `{word1[ADDR_W-1:6],6'b0} + ssid*64`. `resp_s1_ttb` is that descriptor's word 1 with bits [11:0] cleared.
- R9: A context descriptor whose word 0 bit 0 is clear produces fault code 4. With stage 1 off, `resp_s1_ttb` is 0.
- R10: A pending response holds all of its fields while `resp_ready` is 0. No new request is accepted until the response has been taken.
- R11: Any wait before `rd_req_ready` and any gap between data beats is tolerated. `rd_req_valid` and `rd_req_addr` stay stable until the grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_table_base | input | ADDR_W | Base of flat array or directory |
| cfg_two_level | input | 1 | 1 selects the two-level layout |
| cfg_log2size | input | LSZ_W | log2 of the number of stream IDs covered |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Walker idle, request accepted |
| req_sid | input | SID_W | Stream ID |
| req_ssid | input | SSID_W | Substream (task) ID |
| resp_valid | output | 1 | Response present |
| resp_ready | input | 1 | Response taken |
| resp_fault | output | 1 | Walk failed |
| resp_fault_code | output | 3 | 0 none, 1 range, 2 directory, 3 entry, 4 descriptor |
| resp_bypass | output | 1 | No translation applies |
| resp_cfg | output | 2 | {stage-2 on, stage-1 on} |
| resp_vmid | output | VMID_W | Virtual machine ID |
| resp_s1_ttb | output | ADDR_W | Stage-1 table base from descriptor |
| resp_s2_ttb | output | ADDR_W | Stage-2 table base from entry |
| rd_req_valid | output | 1 | Memory read request |
| rd_req_ready | input | 1 | Memory read grant |
| rd_req_addr | output | ADDR_W | Read byte address |
| rd_req_beats | output | 4 | Number of 64-bit beats |
| rd_data_valid | input | 1 | Read data beat present |
| rd_data | input | 64 | Read data beat |

## Verification
A finished response waiting on a stalled consumer can coincide with the next request already asserted on the request side. The bench provokes this after most walks: it holds `resp_ready` low for one or two cycles and presents a different stream ID during that time. It then judges that `req_ready` stayed low, and that every response field at release matches what it was when the response first appeared. The memory model also randomises grant delay and beat gaps, so the last beat of one fetch lands in varying cycles relative to the start of the chained fetch that follows it.

// File: rtl/stw_pkg.sv
package stw_pkg;

    localparam int WORD_W      = 64;
    localparam int ENTRY_BYTES = 64;
    localparam int DESC_BYTES  = 64;
    localparam int DIR_BYTES   = 8;

    localparam int ENTRY_SH = $clog2(ENTRY_BYTES);
    localparam int DESC_SH  = $clog2(DESC_BYTES);
    localparam int DIR_SH   = $clog2(DIR_BYTES);

    localparam int ENTRY_BEATS = ENTRY_BYTES * 8 / WORD_W;
    localparam int DESC_BEATS  = DESC_BYTES * 8 / WORD_W;
    localparam int DIR_BEATS   = DIR_BYTES * 8 / WORD_W;

    localparam int BEAT_W    = 4;
    localparam int KEEP_WORDS = 4;   // entry words 0..3 carry every field used
    localparam int TTB_SH    = 12;   // translation bases are 4 KiB aligned

    typedef enum logic [2:0] {
        FLT_NONE  = 3'd0,
        FLT_RANGE = 3'd1,
        FLT_DIR   = 3'd2,
        FLT_ENTRY = 3'd3,
        FLT_DESC  = 3'd4
    } fault_e;

    typedef enum logic [2:0] {
        W_IDLE,
        W_LAUNCH,
        W_DIR,
        W_ENTRY,
        W_DESC,
        W_RESP
    } walk_e;

    typedef struct packed {
        logic s2_on;
        logic s1_on;
        logic valid;
    } entry_ctl_t;

    function automatic entry_ctl_t decode_ctl(input logic [2:0] low_bits);
        entry_ctl_t c;
        c.valid = low_bits[0];
        c.s1_on = low_bits[1];
        c.s2_on = low_bits[2];
        return c;
    endfunction

    function automatic logic [BEAT_W-1:0] beats_of(input int n);
        return BEAT_W'(n);
    endfunction

endpackage

// File: rtl/stw_addr_calc.sv
module stw_addr_calc
    import stw_pkg::*;
#(
    parameter int SID_W   = 16,
    parameter int SSID_W  = 12,
    parameter int ADDR_W  = 48,
    parameter int SPLIT_W = 8,
    parameter int LSZ_W   = 5
) (
    input  logic [ADDR_W-1:0] base,
    input  logic              two_level,
    input  logic [LSZ_W-1:0]  log2size,
    input  logic [SID_W-1:0]  sid,
    input  logic [SSID_W-1:0] ssid,
    input  logic [ADDR_W-1:0] dir_word,
    input  logic [ADDR_W-1:0] ctx_word,
    output logic              out_of_range,
    output logic [ADDR_W-1:0] dir_addr,
    output logic [ADDR_W-1:0] entry_addr,
    output logic [ADDR_W-1:0] desc_addr
);

    localparam bit HAS_DIR = (SID_W > SPLIT_W);
    localparam int HI_W    = HAS_DIR ? (SID_W - SPLIT_W) : 1;
    localparam int LO_W    = HAS_DIR ? SPLIT_W : SID_W;

    localparam logic [ADDR_W-1:0] ENTRY_MASK = ~((ADDR_W'(1) << ENTRY_SH) - ADDR_W'(1));
    localparam logic [ADDR_W-1:0] DESC_MASK  = ~((ADDR_W'(1) << DESC_SH) - ADDR_W'(1));

    logic [HI_W-1:0]   hi_idx;
    logic [LO_W-1:0]   lo_idx;
    logic [ADDR_W-1:0] leaf_base;

    generate
        if (HAS_DIR) begin : g_split
            assign hi_idx = sid[SID_W-1:SPLIT_W];
            assign lo_idx = sid[SPLIT_W-1:0];
        end else begin : g_flat_only
            assign hi_idx = '0;
            assign lo_idx = sid;
        end
    endgenerate

    always_comb begin
        if (int'(log2size) >= SID_W) begin
            out_of_range = 1'b0;
        end else begin
            out_of_range = ((sid >> log2size) != '0);
        end
    end

    assign leaf_base = dir_word & ENTRY_MASK;
    assign dir_addr  = base + (ADDR_W'(hi_idx) << DIR_SH);

    always_comb begin
        if (two_level) begin
            entry_addr = leaf_base + (ADDR_W'(lo_idx) << ENTRY_SH);
        end else begin
            entry_addr = base + (ADDR_W'(sid) << ENTRY_SH);
        end
    end

    assign desc_addr = (ctx_word & DESC_MASK) + (ADDR_W'(ssid) << DESC_SH);

endmodule

// File: rtl/stw_fetch.sv
module stw_fetch
    import stw_pkg::*;
#(
    parameter int ADDR_W    = 48,
    parameter int CAP_WORDS = KEEP_WORDS
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             start,
    input  logic [ADDR_W-1:0]                start_addr,
    input  logic [BEAT_W-1:0]                start_beats,
    output logic                             rd_req_valid,
    input  logic                             rd_req_ready,
    output logic [ADDR_W-1:0]                rd_req_addr,
    output logic [BEAT_W-1:0]                rd_req_beats,
    input  logic                             rd_data_valid,
    input  logic [WORD_W-1:0]                rd_data,
    output logic                             done,
    output logic [CAP_WORDS-1:0][WORD_W-1:0] words
);

    typedef enum logic [1:0] {F_IDLE, F_REQ, F_DATA} fetch_e;

    fetch_e            st;
    logic [BEAT_W-1:0] cnt;
    logic [BEAT_W-1:0] total;
    logic [ADDR_W-1:0] addr_q;
    logic              done_q;
    logic [WORD_W-1:0] keep_q [CAP_WORDS];

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= F_IDLE;
            cnt    <= '0;
            total  <= '0;
            addr_q <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (st)
                F_IDLE: begin
                    if (start) begin
                        addr_q <= start_addr;
                        total  <= start_beats;
                        cnt    <= '0;
                        st     <= F_REQ;
                    end
                end
                F_REQ: begin
                    if (rd_req_ready) begin
                        st <= F_DATA;
                    end
                end
                F_DATA: begin
                    if (rd_data_valid) begin
                        cnt <= cnt + BEAT_W'(1);
                        if (cnt == total - BEAT_W'(1)) begin
                            st     <= F_IDLE;
                            done_q <= 1'b1;
                        end
                    end
                end
                default: st <= F_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < CAP_WORDS; i++) begin
                keep_q[i] <= '0;
            end
        end else if (st == F_DATA && rd_data_valid) begin
            for (int i = 0; i < CAP_WORDS; i++) begin
                if (cnt == BEAT_W'(i)) begin
                    keep_q[i] <= rd_data;
                end
            end
        end
    end

    generate
        for (genvar g = 0; g < CAP_WORDS; g++) begin : g_out
            assign words[g] = keep_q[g];
        end
    endgenerate

    assign rd_req_valid = (st == F_REQ);
    assign rd_req_addr  = addr_q;
    assign rd_req_beats = total;
    assign done         = done_q;

    assert_req_hold_R11: assert property (@(posedge clk) disable iff (rst)
        rd_req_valid && !rd_req_ready |=> rd_req_valid && $stable(rd_req_addr) && $stable(rd_req_beats))
        else $error("read request dropped or changed before grant");

    assert_no_stray_beat_R11: assert property (@(posedge clk) disable iff (rst)
        rd_data_valid |-> (st == F_DATA))
        else $error("data beat arrived with no read outstanding");

endmodule

// File: rtl/stream_walker.sv
module stream_walker
    import stw_pkg::*;
#(
    parameter int SID_W   = 16,
    parameter int SSID_W  = 12,
    parameter int ADDR_W  = 48,
    parameter int SPLIT_W = 8,
    parameter int VMID_W  = 16,
    localparam int LSZ_W  = $clog2(SID_W + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] cfg_table_base,
    input  logic              cfg_two_level,
    input  logic [LSZ_W-1:0]  cfg_log2size,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [SID_W-1:0]  req_sid,
    input  logic [SSID_W-1:0] req_ssid,
    output logic              resp_valid,
    input  logic              resp_ready,
    output logic              resp_fault,
    output logic [2:0]        resp_fault_code,
    output logic              resp_bypass,
    output logic [1:0]        resp_cfg,
    output logic [VMID_W-1:0] resp_vmid,
    output logic [ADDR_W-1:0] resp_s1_ttb,
    output logic [ADDR_W-1:0] resp_s2_ttb,
    output logic              rd_req_valid,
    input  logic              rd_req_ready,
    output logic [ADDR_W-1:0] rd_req_addr,
    output logic [3:0]        rd_req_beats,
    input  logic              rd_data_valid,
    input  logic [63:0]       rd_data
);

    localparam logic [ADDR_W-1:0] TTB_MASK = ~((ADDR_W'(1) << TTB_SH) - ADDR_W'(1));

    walk_e             st;
    logic [SID_W-1:0]  sid_q;
    logic [SSID_W-1:0] ssid_q;
    fault_e            fault_q;
    logic              bypass_q;
    logic [1:0]        cfg_q;
    logic [VMID_W-1:0] vmid_q;
    logic [ADDR_W-1:0] s1_q;
    logic [ADDR_W-1:0] s2_q;

    logic                             f_start;
    logic [ADDR_W-1:0]                f_addr;
    logic [BEAT_W-1:0]                f_beats;
    logic                             f_done;
    logic [KEEP_WORDS-1:0][WORD_W-1:0] f_words;

    logic              oor;
    logic [ADDR_W-1:0] dir_addr;
    logic [ADDR_W-1:0] entry_addr;
    logic [ADDR_W-1:0] desc_addr;
    entry_ctl_t        ctl;

    logic unused_hi;
    assign unused_hi = ^{f_words[0][WORD_W-1:ADDR_W], f_words[1][WORD_W-1:ADDR_W],
                         f_words[2][WORD_W-1:ADDR_W], f_words[3][WORD_W-1:VMID_W]};

    assign ctl = decode_ctl(f_words[0][2:0]);

    stw_addr_calc #(
        .SID_W   (SID_W),
        .SSID_W  (SSID_W),
        .ADDR_W  (ADDR_W),
        .SPLIT_W (SPLIT_W),
        .LSZ_W   (LSZ_W)
    ) u_addr (
        .base         (cfg_table_base),
        .two_level    (cfg_two_level),
        .log2size     (cfg_log2size),
        .sid          (sid_q),
        .ssid         (ssid_q),
        .dir_word     (f_words[0][ADDR_W-1:0]),
        .ctx_word     (f_words[1][ADDR_W-1:0]),
        .out_of_range (oor),
        .dir_addr     (dir_addr),
        .entry_addr   (entry_addr),
        .desc_addr    (desc_addr)
    );

    stw_fetch #(
        .ADDR_W    (ADDR_W),
        .CAP_WORDS (KEEP_WORDS)
    ) u_fetch (
        .clk           (clk),
        .rst           (rst),
        .start         (f_start),
        .start_addr    (f_addr),
        .start_beats   (f_beats),
        .rd_req_valid  (rd_req_valid),
        .rd_req_ready  (rd_req_ready),
        .rd_req_addr   (rd_req_addr),
        .rd_req_beats  (rd_req_beats),
        .rd_data_valid (rd_data_valid),
        .rd_data       (rd_data),
        .done          (f_done),
        .words         (f_words)
    );

    // fetch launch: one chained read per walk step
    always_comb begin
        f_start = 1'b0;
        f_addr  = entry_addr;
        f_beats = beats_of(ENTRY_BEATS);
        case (st)
            W_LAUNCH: begin
                f_start = !oor;
                if (cfg_two_level) begin
                    f_addr  = dir_addr;
                    f_beats = beats_of(DIR_BEATS);
                end
            end
            W_DIR: begin
                f_start = f_done && ctl.valid;
            end
            W_ENTRY: begin
                f_start = f_done && ctl.valid && ctl.s1_on;
                f_addr  = desc_addr;
                f_beats = beats_of(DESC_BEATS);
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= W_IDLE;
            sid_q    <= '0;
            ssid_q   <= '0;
            fault_q  <= FLT_NONE;
            bypass_q <= 1'b0;
            cfg_q    <= '0;
            vmid_q   <= '0;
            s1_q     <= '0;
            s2_q     <= '0;
        end else begin
            case (st)
                W_IDLE: begin
                    if (req_valid) begin
                        sid_q    <= req_sid;
                        ssid_q   <= req_ssid;
                        fault_q  <= FLT_NONE;
                        bypass_q <= 1'b0;
                        cfg_q    <= '0;
                        vmid_q   <= '0;
                        s1_q     <= '0;
                        s2_q     <= '0;
                        st       <= W_LAUNCH;
                    end
                end
                W_LAUNCH: begin
                    if (oor) begin
                        fault_q <= FLT_RANGE;
                        st      <= W_RESP;
                    end else begin
                        st <= cfg_two_level ? W_DIR : W_ENTRY;
                    end
                end
                W_DIR: begin
                    if (f_done) begin
                        if (!ctl.valid) begin
                            fault_q <= FLT_DIR;
                            st      <= W_RESP;
                        end else begin
                            st <= W_ENTRY;
                        end
                    end
                end
                W_ENTRY: begin
                    if (f_done) begin
                        if (!ctl.valid) begin
                            fault_q <= FLT_ENTRY;
                            st      <= W_RESP;
                        end else begin
                            cfg_q  <= {ctl.s2_on, ctl.s1_on};
                            vmid_q <= f_words[3][VMID_W-1:0];
                            s2_q   <= ctl.s2_on ? (f_words[2][ADDR_W-1:0] & TTB_MASK) : '0;
                            if (ctl.s1_on) begin
                                st <= W_DESC;
                            end else begin
                                bypass_q <= !ctl.s2_on;
                                st       <= W_RESP;
                            end
                        end
                    end
                end
                W_DESC: begin
                    if (f_done) begin
                        if (!ctl.valid) begin
                            fault_q <= FLT_DESC;
                            cfg_q   <= '0;
                            vmid_q  <= '0;
                            s2_q    <= '0;
                        end else begin
                            s1_q <= f_words[1][ADDR_W-1:0] & TTB_MASK;
                        end
                        st <= W_RESP;
                    end
                end
                W_RESP: begin
                    if (resp_ready) begin
                        st <= W_IDLE;
                    end
                end
                default: st <= W_IDLE;
            endcase
        end
    end

    assign req_ready       = (st == W_IDLE);
    assign resp_valid      = (st == W_RESP);
    assign resp_fault      = (fault_q != FLT_NONE);
    assign resp_fault_code = fault_q;
    assign resp_bypass     = bypass_q;
    assign resp_cfg        = cfg_q;
    assign resp_vmid       = vmid_q;
    assign resp_s1_ttb     = s1_q;
    assign resp_s2_ttb     = s2_q;

    assert_resp_stable_R10: assert property (@(posedge clk) disable iff (rst)
        resp_valid && !resp_ready |=> resp_valid && $stable(resp_fault_code) && $stable(resp_bypass)
            && $stable(resp_cfg) && $stable(resp_vmid) && $stable(resp_s1_ttb) && $stable(resp_s2_ttb))
        else $error("pending response changed");

    assert_no_read_in_resp_R10: assert property (@(posedge clk) disable iff (rst)
        resp_valid |-> !rd_req_valid)
        else $error("memory read issued while response pending");

    assert_fault_clean_R5: assert property (@(posedge clk) disable iff (rst)
        resp_valid && resp_fault |-> !resp_bypass && resp_vmid == '0 && resp_cfg == '0
            && resp_s1_ttb == '0 && resp_s2_ttb == '0)
        else $error("faulted response carries field data");

    assert_bypass_clean_R7: assert property (@(posedge clk) disable iff (rst)
        resp_valid && resp_bypass |-> resp_s1_ttb == '0 && resp_s2_ttb == '0 && resp_cfg == '0)
        else $error("bypass response carries stage data");

endmodule

// File: tb/stream_walker_tb.sv
module stream_walker_tb;

    localparam int SID_W  = 10;
    localparam int SSID_W = 6;
    localparam int ADDR_W = 32;
    localparam int VMID_W = 16;
    localparam int LSZ_W  = $clog2(SID_W + 1);

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [ADDR_W-1:0] cfg_table_base = '0;
    logic              cfg_two_level = 1'b0;
    logic [LSZ_W-1:0]  cfg_log2size = LSZ_W'(SID_W);
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [SID_W-1:0]  req_sid = '0;
    logic [SSID_W-1:0] req_ssid = '0;
    logic              resp_valid;
    logic              resp_ready = 1'b0;
    logic              resp_fault;
    logic [2:0]        resp_fault_code;
    logic              resp_bypass;
    logic [1:0]        resp_cfg;
    logic [VMID_W-1:0] resp_vmid;
    logic [ADDR_W-1:0] resp_s1_ttb;
    logic [ADDR_W-1:0] resp_s2_ttb;
    logic              rd_req_valid;
    logic              rd_req_ready = 1'b0;
    logic [ADDR_W-1:0] rd_req_addr;
    logic [3:0]        rd_req_beats;
    logic              rd_data_valid = 1'b0;
    logic [63:0]       rd_data = '0;

    int checks   = 0;
    int failures = 0;
    int log_n    = 0;
    logic [63:0] log_addr [8];
    logic [63:0] log_len  [8];
    logic [15:0] lf = 16'hACE1;
    logic        hold_bad = 1'b0;
    logic        prev_pend = 1'b0;
    logic [ADDR_W-1:0] prev_addr = '0;

    always #4 clk = ~clk;   // 125 MHz

    stream_walker #(
        .SID_W  (SID_W),
        .SSID_W (SSID_W),
        .ADDR_W (ADDR_W),
        .VMID_W (VMID_W)
    ) u_dut (
        .clk             (clk),
        .rst             (rst),
        .cfg_table_base  (cfg_table_base),
        .cfg_two_level   (cfg_two_level),
        .cfg_log2size    (cfg_log2size),
        .req_valid       (req_valid),
        .req_ready       (req_ready),
        .req_sid         (req_sid),
        .req_ssid        (req_ssid),
        .resp_valid      (resp_valid),
        .resp_ready      (resp_ready),
        .resp_fault      (resp_fault),
        .resp_fault_code (resp_fault_code),
        .resp_bypass     (resp_bypass),
        .resp_cfg        (resp_cfg),
        .resp_vmid       (resp_vmid),
        .resp_s1_ttb     (resp_s1_ttb),
        .resp_s2_ttb     (resp_s2_ttb),
        .rd_req_valid    (rd_req_valid),
        .rd_req_ready    (rd_req_ready),
        .rd_req_addr     (rd_req_addr),
        .rd_req_beats    (rd_req_beats),
        .rd_data_valid   (rd_data_valid),
        .rd_data         (rd_data)
    );

    task automatic chk(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] entry_word(input int sid, input int k);
        logic [63:0] c;
        c = 64'(sid % 4);
        case (k)
            0: return 64'hA5A5_0000_0000_00F8 | 64'((sid % 7) != 3) | (c << 1);
            1: return 64'h7700_0000_0000_0000 | (64'h40_0000 + 64'(sid) * 64'h1000) | 64'h15;
            2: return 64'h5500_0000_0000_0000 | (64'h20_0000 + 64'(sid) * 64'h1000) | 64'h3C5;
            3: return 64'hCAFE_0000_BEEF_0000 | 64'((sid * 37) & 16'hFFFF);
            default: return 64'hDEAD_BEEF_0000_0000 | 64'(sid);
        endcase
    endfunction

    function automatic logic [63:0] desc_word(input int sid, input int ssid, input int k);
        case (k)
            0: return 64'hFF00_0000_0000_00F0 | 64'((ssid % 16) != 9);
            1: return 64'h3300_0000_0000_0ABC | (64'(sid) << 12) | (64'(ssid) << 22);
            default: return 64'h0BAD_0000_0000_0000 | 64'(ssid);
        endcase
    endfunction

    function automatic logic [63:0] dir_word(input int idx);
        return 64'h8800_0000_0000_0020 | (64'h10_0000 + 64'(idx) * 64'h1_0000) | 64'(idx != 2);
    endfunction

    function automatic logic [63:0] mem_word(input logic [63:0] a);
        int k;
        k = int'((a >> 3) & 64'h7);
        if (a >= 64'h1_0000 && a < 64'h2_0000) return entry_word(int'((a - 64'h1_0000) >> 6), k);
        if (a >= 64'h3_0000 && a < 64'h3_0020) return dir_word(int'((a - 64'h3_0000) >> 3));
        if (a >= 64'h10_0000 && a < 64'h14_0000)
            return entry_word(int'((a - 64'h10_0000) >> 16) * 256 + int'(((a - 64'h10_0000) & 64'hFFFF) >> 6), k);
        if (a >= 64'h40_0000 && a < 64'h80_0000)
            return desc_word(int'((a - 64'h40_0000) >> 12), int'((a >> 6) & 64'h3F), k);
        return 64'h0;
    endfunction

    function automatic logic [15:0] lf_next(input logic [15:0] v);
        return {v[14:0], v[15] ^ v[13] ^ v[12] ^ v[10]};
    endfunction

    // memory responder: random grant delay and random beat gaps (R11)
    initial begin
        logic [63:0] a;
        int n;
        forever begin
            @(negedge clk);
            rd_data_valid = 1'b0;
            lf = lf_next(lf);
            rd_req_ready = lf[0] | lf[3];
            if (rd_req_valid && rd_req_ready && !rst) begin
                a = 64'(rd_req_addr);
                n = int'(rd_req_beats);
                if (log_n < 8) begin
                    log_addr[log_n] = a;
                    log_len[log_n]  = 64'(n);
                end
                log_n++;
                @(negedge clk);
                rd_req_ready = 1'b0;
                for (int k = 0; k < n; k++) begin
                    lf = lf_next(lf);
                    repeat (int'(lf[1:0]) % 3) @(negedge clk);
                    rd_data_valid = 1'b1;
                    rd_data = mem_word(a + 64'(k) * 64'd8);
                    @(negedge clk);
                    rd_data_valid = 1'b0;
                end
            end
        end
    end

    // request-hold monitor (R11)
    always @(negedge clk) begin
        if (!rst) begin
            if (prev_pend && (!rd_req_valid || rd_req_addr != prev_addr)) hold_bad = 1'b1;
            prev_pend = rd_req_valid && !rd_req_ready;
            prev_addr = rd_req_addr;
        end
    end

    task automatic do_txn(input int sid, input int ssid, input logic two, input int lsz);
        logic [63:0] ea [3];
        logic [63:0] el [3];
        int en;
        int efc;
        logic ebyp;
        logic [1:0] ecfg;
        logic [63:0] evm, es1, es2;
        logic oor, s1, s2;
        logic [2:0] h_fc;
        logic h_byp;
        logic [1:0] h_cfg;
        logic [VMID_W-1:0] h_vm;
        logic [ADDR_W-1:0] h_s1, h_s2;
        string tg;
        int w;

        en = 0; efc = 0; ebyp = 0; ecfg = 0; evm = 0; es1 = 0; es2 = 0;
        s1 = (sid % 4) & 1;
        s2 = ((sid % 4) >> 1) & 1;
        oor = (lsz < SID_W) && ((sid >> lsz) != 0);
        tg = two ? "R3" : "R2";
        if (oor) begin
            efc = 1; tg = "R4";
        end else begin
            if (two) begin
                ea[en] = 64'h3_0000 + 64'(sid >> 8) * 8; el[en] = 1; en++;
            end
            if (two && (sid >> 8) == 2) begin
                efc = 2; tg = "R5";
            end else begin
                ea[en] = two ? (64'h10_0000 + 64'(sid >> 8) * 64'h1_0000 + 64'(sid & 255) * 64)
                             : (64'h1_0000 + 64'(sid) * 64);
                el[en] = 8; en++;
                if ((sid % 7) == 3) begin
                    efc = 3; tg = "R5";
                end else if (s1) begin
                    ea[en] = 64'h40_0000 + 64'(sid) * 64'h1000 + 64'(ssid) * 64; el[en] = 8; en++;
                    if ((ssid % 16) == 9) begin
                        efc = 4; tg = "R9";
                    end else begin
                        tg = "R8";
                        es1 = (64'(sid) << 12) | (64'(ssid) << 22);
                    end
                end else if (!s2) begin
                    tg = "R7"; ebyp = 1;
                end else begin
                    tg = "R9";
                end
                if (efc == 0) begin
                    ecfg = {s2, s1};
                    evm  = 64'((sid * 37) & 16'hFFFF);
                    es2  = s2 ? (64'h20_0000 + 64'(sid) * 64'h1000) : 64'h0;
                end
            end
        end

        @(negedge clk);
        cfg_two_level  = two;
        cfg_table_base = two ? 32'h3_0000 : 32'h1_0000;
        cfg_log2size   = LSZ_W'(lsz);
        log_n = 0;
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1;
        req_sid   = SID_W'(sid);
        req_ssid  = SSID_W'(ssid);
        @(negedge clk);
        req_valid = 1'b0;
        while (!resp_valid) @(negedge clk);

        h_fc = resp_fault_code; h_byp = resp_bypass; h_cfg = resp_cfg;
        h_vm = resp_vmid; h_s1 = resp_s1_ttb; h_s2 = resp_s2_ttb;
        w = sid % 3;
        for (int s = 0; s < w; s++) begin
            req_valid = 1'b1;
            req_sid   = SID_W'(sid ^ 1);
            @(negedge clk);
            chk(!req_ready && resp_valid, "R10 busy during stall", 64'(req_ready), 64'h0);
        end
        req_valid = 1'b0;
        if (w > 0) begin
            chk(resp_fault_code == h_fc && resp_bypass == h_byp && resp_cfg == h_cfg &&
                resp_vmid == h_vm && resp_s1_ttb == h_s1 && resp_s2_ttb == h_s2,
                "R10 response stable", 64'(resp_s1_ttb), 64'(h_s1));
        end

        chk(int'(resp_fault_code) == efc && resp_fault == (efc != 0),
            {tg, " fault code"}, 64'(resp_fault_code), 64'(efc));
        chk(resp_bypass == ebyp, "R7 bypass", 64'(resp_bypass), 64'(ebyp));
        chk(resp_cfg == ecfg && 64'(resp_vmid) == evm, "R6 cfg/vmid",
            {32'(resp_cfg), 16'h0, resp_vmid}, {32'(ecfg), evm[31:0]});
        chk(64'(resp_s2_ttb) == es2, "R6 stage-2 base", 64'(resp_s2_ttb), es2);
        chk(64'(resp_s1_ttb) == es1, "R8 stage-1 base", 64'(resp_s1_ttb), es1);

        resp_ready = 1'b1;
        @(negedge clk);
        resp_ready = 1'b0;

        chk(log_n == en, {tg, " read count"}, 64'(log_n), 64'(en));
        for (int i = 0; i < en && i < log_n; i++) begin
            chk(log_addr[i] == ea[i] && log_len[i] == el[i], {tg, " read addr/len"},
                log_addr[i], ea[i]);
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL R11 watchdog actual=hung expected=completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(req_ready == 1'b1, "R1 req_ready after reset", 64'(req_ready), 64'h1);
        chk(resp_valid == 1'b0, "R1 resp_valid after reset", 64'(resp_valid), 64'h0);
        chk(rd_req_valid == 1'b0, "R1 rd_req_valid after reset", 64'(rd_req_valid), 64'h0);

        // full sweep, flat layout
        for (int s = 0; s < (1 << SID_W); s++) do_txn(s, (s * 5) % 64, 1'b0, SID_W);
        // full sweep, two-level layout
        for (int s = 0; s < (1 << SID_W); s++) do_txn(s, (s * 5) % 64, 1'b1, SID_W);
        // range boundary both sides, both layouts (R4)
        for (int s = 500; s < 530; s++) do_txn(s, s % 64, 1'b0, 9);
        for (int s = 250; s < 262; s++) do_txn(s, s % 64, 1'b1, 8);
        do_txn(0, 0, 1'b0, 0);
        do_txn(1, 0, 1'b0, 0);

        chk(!hold_bad, "R11 read request held until grant", 64'(hold_bad), 64'h0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule